// File: doc/BRIEF.md
# Four-Switch Buck-Boost PWM Generator with Programmable Dead Time

This block drives the four gates of a single-inductor, four-switch buck-boost bridge: a high-side and a low-side switch on the input (buck) leg and a high-side and a low-side switch on the output (boost) leg. A free-running 8-bit period counter advances on a clock enable running at 256 times the chosen switching frequency. That counter is compared against a 9-bit duty command to form one request per leg: "main switch on" or "rectifier on". On the buck leg the main switch is the high side. On the boost leg the main switch is the low side.

Each leg turns its request into two gate signals and leaves a gap at every edge. The gap before a main switch turns on and the gap before a rectifier turns on are set by two separate 3-bit codes. Both codes count in 1/256ths of the switching period, so each gap scales with the frequency.

A half-frequency bypass request runs both legs at half the switching frequency with equal 50 % requests. The buck gain of one half and the boost gain of two then cancel to an overall ratio of one, and the dead-time codes apply unchanged.

All controls are taken in only at a period boundary, so no runt pulse can appear. A low level on the reset pin forces all four gates off in the same cycle.

Top module: `bbpwm_bridge`

## Requirements
- R1: `period_strobe` is a single-clock pulse once per period. A period is 256 ticks. One tick lasts DIV_LO, DIV_MED or DIV_HI clocks for `freq_sel` codes 0, 1 and 2 respectively; code 3 behaves as code 2.
- R2: `gate_buck_hi` and `gate_buck_lo` are never high in the same cycle. The same holds for `gate_boost_hi` and `gate_boost_lo`.
- R3: With `duty_cmd[8]`=0 (buck mode) and d=`duty_cmd[7:0]` in 1..255, each period holds `gate_buck_hi` high for max(d−M,0) ticks and `gate_buck_lo` high for max(256−d−S,0) ticks. Here M is `dt_main_code` and S is `dt_rect_code`. `gate_boost_hi` stays high and `gate_boost_lo` stays low.
- R4: With `duty_cmd[8]`=1 (boost mode), `gate_boost_lo` is the main switch with max(d−M,0) ticks and `gate_boost_hi` the rectifier with max(256−d−S,0) ticks. `gate_buck_hi` stays high and `gate_buck_lo` stays low.
- R5: When d=0 the switching leg never turns its main switch on, and its rectifier stays high for the whole period.
- R6: On a switching leg, the main switch rises exactly M ticks after the rectifier falls.
- R7: With `half_bypass`=1, `duty_cmd` is ignored. A tick then lasts twice as many clocks, so a period is 512 base ticks. Both legs switch with a request of 128 of 256 ticks: `gate_buck_hi` and `gate_boost_lo` are high for 128−M ticks, and `gate_buck_lo` and `gate_boost_hi` for 128−S ticks.
- R8: Duty, mode, frequency, bypass and both dead-time codes are captured only when the period counter wraps. A change in the middle of a period leaves that period's gate timing unchanged.
- R9: While `rst_n` is low, all four gates are low in the same cycle. After reset is released, the first period runs at the high frequency with d=0 in buck mode and both dead-time codes at 3, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; gates are forced off at once |
| duty_cmd | input | 9 | Bit 8 selects boost mode; bits 7:0 give the on-request length in ticks |
| freq_sel | input | 2 | 0 low, 1 medium, 2 or 3 high switching frequency |
| dt_rect_code | input | 3 | Gap before a rectifier turns on, in ticks |
| dt_main_code | input | 3 | Gap before a main switch turns on, in ticks |
| half_bypass | input | 1 | Half-frequency unity-ratio bypass request |
| gate_buck_hi | output | 1 | Buck leg high-side gate (main switch) |
| gate_buck_lo | output | 1 | Buck leg low-side gate (rectifier) |
| gate_boost_hi | output | 1 | Boost leg high-side gate (rectifier) |
| gate_boost_lo | output | 1 | Boost leg low-side gate (main switch) |
| period_strobe | output | 1 | One-clock pulse at each period wrap |

## Verification
The assertions assume that `rst_n` is held low long enough to clear every register. They also assume that DIV_LO, DIV_MED and DIV_HI are the only tick lengths, so every strobe-to-strobe gap must be 256 times one of those values, either alone or doubled. The stimulus changes inputs only at the falling clock edge and leaves each setting in place for two full periods before measuring. In that way each measured period is a steady repetition of one setting, except in the deliberate mid-period change that checks R8.

// File: rtl/bbpwm_pkg.sv
package bbpwm_pkg;
  localparam int CNT_W  = 8;
  localparam int DUTY_W = CNT_W + 1;
  localparam int DT_W   = 3;
  localparam logic [DT_W-1:0] DT_DEFAULT = 3'd3;

  typedef enum logic [1:0] {
    FSEL_LOW  = 2'd0,
    FSEL_MED  = 2'd1,
    FSEL_HIGH = 2'd2,
    FSEL_TOP  = 2'd3
  } fsel_t;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic              bypass;
    fsel_t             fsel;
    logic [DT_W-1:0]   rect_dt;
    logic [DT_W-1:0]   main_dt;
  } cfg_t;
endpackage

// File: rtl/bbpwm_tick_div.sv
module bbpwm_tick_div
  import bbpwm_pkg::*;
#(
  parameter int DIV_LO  = 8,
  parameter int DIV_MED = 6,
  parameter int DIV_HI  = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  fsel_t fsel,
  input  logic  bypass,
  output logic  tick
);
  localparam int MAXDIV = (DIV_LO > DIV_MED) ? ((DIV_LO > DIV_HI) ? DIV_LO : DIV_HI)
                                             : ((DIV_MED > DIV_HI) ? DIV_MED : DIV_HI);
  localparam int DCW = $clog2(2 * MAXDIV + 1);

  logic [DCW-1:0] base;
  logic [DCW-1:0] div_eff;
  logic [DCW-1:0] dcnt;

  always_comb begin
    case (fsel)
      FSEL_LOW: base = DCW'(DIV_LO);
      FSEL_MED: base = DCW'(DIV_MED);
      default:  base = DCW'(DIV_HI);
    endcase
    div_eff = bypass ? (base << 1) : base;
  end

  assign tick = (dcnt == div_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)       dcnt <= '0;
    else if (tick) dcnt <= '0;
    else           dcnt <= dcnt + 1'b1;
  end
endmodule

// File: rtl/bbpwm_frame.sv
module bbpwm_frame
  import bbpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cfg_t             cfg_in,
  output logic [CNT_W-1:0] cnt,
  output cfg_t             cfg_q,
  output logic             strobe
);
  localparam cfg_t CFG_RESET = '{duty: '0, bypass: 1'b0, fsel: FSEL_HIGH,
                                 rect_dt: DT_DEFAULT, main_dt: DT_DEFAULT};

  logic wrap;
  assign wrap = tick && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cfg_q  <= CFG_RESET;
      strobe <= 1'b0;
    end else begin
      strobe <= wrap;
      if (tick) cnt <= cnt + 1'b1;
      if (wrap) cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/bbpwm_leg.sv
module bbpwm_leg
  import bbpwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            req,
  input  logic [DT_W-1:0] rect_dt,
  input  logic [DT_W-1:0] main_dt,
  output logic            main_q,
  output logic            rect_q
);
  logic            prev_req;
  logic            seen;
  logic [DT_W-1:0] age;
  logic [DT_W-1:0] age_now;

  // ticks the current request level has already been held (saturating)
  always_comb begin
    if (seen && (req == prev_req)) age_now = (age == '1) ? age : age + 1'b1;
    else                           age_now = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_req <= 1'b0;
      seen     <= 1'b0;
      age      <= '0;
      main_q   <= 1'b0;
      rect_q   <= 1'b0;
    end else if (tick) begin
      prev_req <= req;
      seen     <= 1'b1;
      age      <= age_now;
      main_q   <= req && (age_now >= main_dt);
      rect_q   <= !req && (age_now >= rect_dt);
    end
  end
endmodule

// File: rtl/bbpwm_bridge.sv
module bbpwm_bridge
  import bbpwm_pkg::*;
#(
  parameter int DIV_LO  = 8,
  parameter int DIV_MED = 6,
  parameter int DIV_HI  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic [1:0]        freq_sel,
  input  logic [DT_W-1:0]   dt_rect_code,
  input  logic [DT_W-1:0]   dt_main_code,
  input  logic              half_bypass,
  output logic              gate_buck_hi,
  output logic              gate_buck_lo,
  output logic              gate_boost_hi,
  output logic              gate_boost_lo,
  output logic              period_strobe
);
  localparam int NLEG = 2;
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic             rst;
  logic             tick;
  cfg_t             cfg_in;
  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt;
  logic [NLEG-1:0]  req;
  logic [NLEG-1:0]  main_q;
  logic [NLEG-1:0]  rect_q;
  logic             boost_mode;
  logic             pwm_req;
  logic             half_req;

  assign rst    = !rst_n;
  assign cfg_in = '{duty: duty_cmd, bypass: half_bypass, fsel: fsel_t'(freq_sel),
                    rect_dt: dt_rect_code, main_dt: dt_main_code};

  bbpwm_tick_div #(.DIV_LO(DIV_LO), .DIV_MED(DIV_MED), .DIV_HI(DIV_HI)) u_div (
    .clk    (clk),
    .rst    (rst),
    .fsel   (cfg_q.fsel),
    .bypass (cfg_q.bypass),
    .tick   (tick)
  );

  bbpwm_frame u_frame (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .cfg_in (cfg_in),
    .cnt    (cnt),
    .cfg_q  (cfg_q),
    .strobe (period_strobe)
  );

  assign boost_mode = cfg_q.duty[DUTY_W-1];
  assign pwm_req    = cnt < cfg_q.duty[CNT_W-1:0];
  assign half_req   = cnt < HALF;

  // leg 0: buck, main = high side; leg 1: boost, main = low side
  assign req[0] = cfg_q.bypass ? half_req : (boost_mode ? 1'b1 : pwm_req);
  assign req[1] = cfg_q.bypass ? half_req : (boost_mode ? pwm_req : 1'b0);

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    bbpwm_leg u_leg (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .req     (req[g]),
      .rect_dt (cfg_q.rect_dt),
      .main_dt (cfg_q.main_dt),
      .main_q  (main_q[g]),
      .rect_q  (rect_q[g])
    );
  end

  assign gate_buck_hi  = main_q[0] & rst_n;
  assign gate_buck_lo  = rect_q[0] & rst_n;
  assign gate_boost_lo = main_q[1] & rst_n;
  assign gate_boost_hi = rect_q[1] & rst_n;
endmodule

// File: rtl/bbpwm_bridge_chk.sv
module bbpwm_bridge_chk
  import bbpwm_pkg::*;
#(
  parameter int DIV_LO  = 8,
  parameter int DIV_MED = 6,
  parameter int DIV_HI  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic gate_buck_hi,
  input logic gate_buck_lo,
  input logic gate_boost_hi,
  input logic gate_boost_lo,
  input logic period_strobe
);
  localparam int unsigned PT = 1 << CNT_W;

  int unsigned clk_gap;

  always_ff @(posedge clk) begin
    if (!rst_n)             clk_gap <= 0;
    else if (period_strobe) clk_gap <= 1;
    else                    clk_gap <= clk_gap + 1;
  end

  function automatic logic gap_ok(input int unsigned g);
    return (g == PT * DIV_LO) || (g == PT * DIV_MED) || (g == PT * DIV_HI) ||
           (g == 2 * PT * DIV_LO) || (g == 2 * PT * DIV_MED) || (g == 2 * PT * DIV_HI);
  endfunction

  AST_BUCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_buck_hi && gate_buck_lo)); // R2
  AST_BOOST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_boost_hi && gate_boost_lo)); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |=> !period_strobe); // R1
  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |-> gap_ok(clk_gap)); // R1
  AST_RELEASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !(gate_buck_hi || gate_buck_lo || gate_boost_hi || gate_boost_lo)); // R9
endmodule

bind bbpwm_bridge bbpwm_bridge_chk #(.DIV_LO(DIV_LO), .DIV_MED(DIV_MED), .DIV_HI(DIV_HI)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .gate_buck_hi  (gate_buck_hi),
  .gate_buck_lo  (gate_buck_lo),
  .gate_boost_hi (gate_boost_hi),
  .gate_boost_lo (gate_boost_lo),
  .period_strobe (period_strobe)
);

// File: tb/bbpwm_bridge_tb.sv
module bbpwm_bridge_tb;
  localparam int TB_LO  = 4;
  localparam int TB_MED = 3;
  localparam int TB_HI  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] duty_cmd = '0;
  logic [1:0] freq_sel = 2'd2;
  logic [2:0] dt_rect_code = 3'd3;
  logic [2:0] dt_main_code = 3'd3;
  logic       half_bypass = 1'b0;
  logic       gate_buck_hi, gate_buck_lo, gate_boost_hi, gate_boost_lo, period_strobe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  int m_per, m_hia, m_lia, m_hib, m_lib, m_gap_a, m_gap_b;
  int pend_at = -1;
  logic [8:0] pend_duty;
  logic [1:0] pend_fs;
  logic [2:0] pend_rect, pend_main;
  logic       pend_byp;

  bbpwm_bridge #(.DIV_LO(TB_LO), .DIV_MED(TB_MED), .DIV_HI(TB_HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .freq_sel(freq_sel),
    .dt_rect_code(dt_rect_code), .dt_main_code(dt_main_code), .half_bypass(half_bypass),
    .gate_buck_hi(gate_buck_hi), .gate_buck_lo(gate_buck_lo),
    .gate_boost_hi(gate_boost_hi), .gate_boost_lo(gate_boost_lo),
    .period_strobe(period_strobe)
  );

  always #2ns clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R2: both switches of one leg never high together
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if ((gate_buck_hi && gate_buck_lo) || (gate_boost_hi && gate_boost_lo)) begin
        n_bad++;
        $display("FAIL R2: actual buck %b%b boost %b%b expected no pair both high",
                 gate_buck_hi, gate_buck_lo, gate_boost_hi, gate_boost_lo);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic set_cfg(input logic [8:0] d, input logic byp, input logic [1:0] fs,
                         input logic [2:0] rc, input logic [2:0] mc);
    duty_cmd = d; half_bypass = byp; freq_sel = fs; dt_rect_code = rc; dt_main_code = mc;
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!period_strobe);
  endtask

  task automatic measure();
    logic ph, pl, bh, bl;
    int fa, fb;
    wait_strobe();
    m_per = 0; m_hia = 0; m_lia = 0; m_hib = 0; m_lib = 0;
    m_gap_a = -1; m_gap_b = -1; fa = -1; fb = -1;
    ph = gate_buck_hi; pl = gate_buck_lo; bh = gate_boost_hi; bl = gate_boost_lo;
    forever begin
      if (pl && !gate_buck_lo) fa = m_per;
      if (!ph && gate_buck_hi && fa >= 0) m_gap_a = m_per - fa;
      if (bh && !gate_boost_hi) fb = m_per;
      if (!bl && gate_boost_lo && fb >= 0) m_gap_b = m_per - fb;
      m_hia += int'(gate_buck_hi); m_lia += int'(gate_buck_lo);
      m_hib += int'(gate_boost_hi); m_lib += int'(gate_boost_lo);
      ph = gate_buck_hi; pl = gate_buck_lo; bh = gate_boost_hi; bl = gate_boost_lo;
      m_per++;
      @(negedge clk);
      if (m_per == pend_at) set_cfg(pend_duty, pend_byp, pend_fs, pend_rect, pend_main);
      if (period_strobe) break;
    end
  endtask

  task automatic run_case(input logic [8:0] d9, input logic byp, input logic [1:0] fs,
                          input int rc, input int mc);
    int dv, deff, d, m, r, e_hia, e_lia, e_hib, e_lib;
    string t;
    set_cfg(d9, byp, fs, 3'(rc), 3'(mc));
    wait_strobe();
    wait_strobe();
    measure();
    dv = (fs == 2'd0) ? TB_LO : ((fs == 2'd1) ? TB_MED : TB_HI);
    deff = byp ? 2 * dv : dv;
    d = int'(d9[7:0]);
    if (byp) begin
      t = "R7";
      e_hia = 128 - mc; e_lib = 128 - mc; e_lia = 128 - rc; e_hib = 128 - rc;
    end else begin
      m = (d > mc) ? d - mc : 0;
      r = (d == 0) ? 256 : ((256 - d > rc) ? 256 - d - rc : 0);
      t = (d == 0) ? "R5" : (d9[8] ? "R4" : "R3");
      if (!d9[8]) begin e_hia = m; e_lia = r; e_hib = 256; e_lib = 0; end
      else        begin e_lib = m; e_hib = r; e_hia = 256; e_lia = 0; end
    end
    chk(byp ? "R7 period" : "R1 period", m_per, 256 * deff);
    chk({t, " buck_hi"}, m_hia, e_hia * deff);
    chk({t, " buck_lo"}, m_lia, e_lia * deff);
    chk({t, " boost_hi"}, m_hib, e_hib * deff);
    chk({t, " boost_lo"}, m_lib, e_lib * deff);
    if ((byp || !d9[8]) && e_hia > 0 && e_hia < 256 && e_lia > 0)
      chk("R6 buck gap", m_gap_a, mc * deff);
    if ((byp || d9[8]) && e_lib > 0 && e_hib > 0 && e_hib < 256)
      chk("R6 boost gap", m_gap_b, mc * deff);
  endtask

  // R9: first period after release uses the reset configuration
  task automatic first_window();
    int per, hia, lia, hib;
    per = 0; hia = 0; lia = 0; hib = 0;
    set_cfg(9'd100, 1'b0, 2'd0, 3'd0, 3'd0);
    repeat (3) @(negedge clk);
    chk("R9 reset buck_hi", int'(gate_buck_hi), 0);
    chk("R9 reset boost_hi", int'(gate_boost_hi), 0);
    chk("R9 reset strobe", int'(period_strobe), 0);
    rst_n = 1'b1;
    forever begin
      @(negedge clk);
      if (period_strobe) break;
      per++;
      hia += int'(gate_buck_hi); lia += int'(gate_buck_lo); hib += int'(gate_boost_hi);
    end
    chk("R9 first period length", per, 256 * TB_HI - 1);
    chk("R9 first buck_hi", hia, 0);
    chk("R9 first buck_lo", lia, 252 * TB_HI);
    chk("R9 first boost_hi", hib, 252 * TB_HI);
  endtask

  initial begin
    int buck_d[11];
    int boost_d[5];
    buck_d = '{0, 1, 3, 4, 5, 64, 128, 200, 252, 253, 255};
    boost_d = '{0, 3, 4, 100, 255};

    first_window();

    foreach (buck_d[i]) run_case(9'(buck_d[i]), 1'b0, 2'd2, 3, 3);
    for (int k = 0; k < 4; k++) begin
      int rc, mc;
      rc = (k == 0) ? 0 : ((k == 1) ? 7 : ((k == 2) ? 1 : 6));
      mc = (k == 0) ? 0 : ((k == 1) ? 7 : ((k == 2) ? 6 : 1));
      run_case(9'd2, 1'b0, 2'd2, rc, mc);
      run_case(9'd100, 1'b0, 2'd2, rc, mc);
      run_case(9'd250, 1'b0, 2'd2, rc, mc);
    end
    foreach (boost_d[i]) begin
      run_case(9'(256 + boost_d[i]), 1'b0, 2'd2, 3, 3);
      run_case(9'(256 + boost_d[i]), 1'b0, 2'd3, 2, 5);
    end
    run_case(9'd100, 1'b0, 2'd0, 3, 3);       // R1 low
    run_case(9'd100, 1'b0, 2'd1, 3, 3);       // R1 medium
    run_case(9'd300, 1'b1, 2'd2, 3, 3);       // R7
    run_case(9'd40, 1'b1, 2'd0, 1, 2);        // R7

    // R8: mid-period change has no effect on the running period
    run_case(9'd100, 1'b0, 2'd2, 3, 3);
    pend_duty = 9'd200; pend_byp = 1'b0; pend_fs = 2'd0; pend_rect = 3'd0; pend_main = 3'd0;
    pend_at = 100;
    measure();
    pend_at = -1;
    chk("R8 period", m_per, 256 * TB_HI);
    chk("R8 buck_hi", m_hia, 97 * TB_HI);
    chk("R8 buck_lo", m_lia, 153 * TB_HI);
    run_case(9'd200, 1'b0, 2'd0, 0, 0);

    // R9: reset forces gates off within the same cycle
    run_case(9'd10, 1'b0, 2'd2, 3, 3);
    chk("R3 boost_hi held before reset", int'(gate_boost_hi), 1);
    rst_n = 1'b0;
    #1ns;
    chk("R9 immediate buck_hi", int'(gate_buck_hi), 0);
    chk("R9 immediate buck_lo", int'(gate_buck_lo), 0);
    chk("R9 immediate boost_hi", int'(gate_boost_hi), 0);
    chk("R9 immediate boost_lo", int'(gate_boost_lo), 0);
    first_window();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule